// File: doc/BRIEF.md
# Drift-Adjusted Time-of-Day Counter

This block keeps a precision time of day, as 48-bit seconds and 32-bit nanoseconds, in a single 125 MHz clock domain. A raw counter normally advances by 8 ns on each clock. A signed 30-bit fractional-nanosecond accumulator receives a programmable drift rate on every cycle. When the accumulator carries, that cycle's step becomes 9 ns. When it borrows, the step becomes 7 ns. Software can therefore trim the counter's frequency very finely without touching the clock.

A programmable signed offset, made of seconds and nanoseconds, is added after the raw counter to form the synchronized time. The sum is normalized, so its nanosecond field always stays within a second. A heartbeat input from outside is synchronized into the clock domain. On each detected rising edge, the synchronized time is captured into registers that software can read and compare with an external reference. Software sets the drift rate and the offset, loads an absolute time and reads the capture through a small register port with one write strobe and a combinational read.

Top module: `tod_sync_clock`

## Requirements
- R1: After a clock edge with `rst_n` low, the raw time, the accumulator, every register and both capture registers are zero, so `sync_sec`, `sync_ns` and every register read return 0.
- R2: With a drift rate of zero, the time advances by exactly 8 ns on each clock edge.
- R3: The drift rate is written at address 0x0. Bits [29:0] hold a two's-complement value, and a read returns it sign-extended to 32 bits. Each cycle the rate is added to a 30-bit signed accumulator. If the sum is 2^29 or more, that cycle's step is 9 ns and 2^30 is subtracted from the sum. If the sum is below -2^29, the step is 7 ns and 2^30 is added. Otherwise the step is 8 ns.
- R4: When the nanoseconds plus the step reach 10^9 or more, the nanoseconds take the excess above 10^9 and the seconds increase by one, modulo 2^48. This holds for 7, 8 and 9 ns steps. The raw nanoseconds stay below 10^9 at all times.
- R5: The synchronized outputs equal the raw time plus an offset. The offset nanoseconds are at address 0x1, a signed 32-bit value saturated to ±999,999,999. The offset seconds are a 48-bit two's-complement value, with the low 32 bits at address 0x2 and the upper 16 bits at address 0x3 bits [15:0]. A negative nanosecond sum adds 10^9 and borrows one second. A sum of 10^9 or more subtracts 10^9 and carries one second. The outputs follow the raw time and the offset without a register stage.
- R6: A written register value is in use from the following clock edge on. The load value is set by 0x4 (nanoseconds), 0x5 (seconds, low 32 bits) and 0x6 (seconds, bits [15:0] of the upper 16). A write to 0x7 sets the raw time to that load value on its own edge, in place of the normal step. A load nanosecond value of 10^9 or more is loaded as 999,999,999. A load does not disturb the accumulator.
- R7: The heartbeat passes through a two-flop synchronizer. On a detected low-to-high change, the capture registers take the synchronized time that is present just before the third clock edge that sees the heartbeat high. A heartbeat that stays high captures only once.
- R8: The capture is read at 0x8 (nanoseconds), 0x9 (seconds, low 32 bits) and 0xA (seconds, upper 16 bits in [15:0]). Registers 0x0 to 0x6 read back as written, with unused upper bits reading zero. Address 0x7 and unmapped addresses read 0. `reg_rdata` follows `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| heartbeat | input | 1 | Asynchronous heartbeat; a rising edge captures the time |
| sync_sec | output | 48 | Synchronized seconds |
| sync_ns | output | 32 | Synchronized nanoseconds, always below 10^9 |

## Verification
The assertions check several properties on every cycle. Without a load, each raw step is 7, 8 or 9 ns, and the seconds move only on a nanosecond wrap. Both the raw and the synchronized nanoseconds stay below 10^9. After an accumulator carry the accumulator is negative, and after a borrow it is non-negative. The capture registers change only on a detected heartbeat edge, and they then hold the time seen on the cycle before. Other behaviours need the bench's reference model and scenarios. These are the exact carry pattern for each drift rate, the values around a wrap under 7 and 9 ns steps, offset borrow, carry and saturation, load clamping, the one-cycle delay of register writes, and the heartbeat latency and single capture for a held level.

// File: rtl/tod_pkg.sv
package tod_pkg;
    // Field widths of the time format and of the register port
    localparam int SEC_W   = 48;
    localparam int NS_W    = 32;
    localparam int FRAC_W  = 30;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int STEP_W  = 4;
    // Nominal nanoseconds added per reference clock
    localparam int NOM_STEP = 8;
    // One second in nanoseconds and the largest legal nanosecond value
    localparam logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000;
    localparam logic [NS_W-1:0] NS_MAX     = NS_PER_SEC - 1'b1;
    // Register addresses
    localparam logic [ADDR_W-1:0] RA_DRIFT      = 4'h0;
    localparam logic [ADDR_W-1:0] RA_OFF_NS     = 4'h1;
    localparam logic [ADDR_W-1:0] RA_OFF_SEC_LO = 4'h2;
    localparam logic [ADDR_W-1:0] RA_OFF_SEC_HI = 4'h3;
    localparam logic [ADDR_W-1:0] RA_LD_NS      = 4'h4;
    localparam logic [ADDR_W-1:0] RA_LD_SEC_LO  = 4'h5;
    localparam logic [ADDR_W-1:0] RA_LD_SEC_HI  = 4'h6;
    localparam logic [ADDR_W-1:0] RA_LD_GO      = 4'h7;
    localparam logic [ADDR_W-1:0] RA_CAP_NS     = 4'h8;
    localparam logic [ADDR_W-1:0] RA_CAP_SEC_LO = 4'h9;
    localparam logic [ADDR_W-1:0] RA_CAP_SEC_HI = 4'hA;
endpackage

// File: rtl/tod_drift_accum.sv
// Fractional-nanosecond drift accumulator.
// Adds the signed drift rate to a signed accumulator each cycle. A carry out
// of the positive range gives a step one above nominal, a borrow below the
// negative range gives a step one below nominal.
// Assumes: the rate is a two's-complement value of FRAC_W bits, so at most
// one carry or borrow can occur per cycle.
module tod_drift_accum #(
    parameter int FRAC_W   = 30,
    parameter int STEP_W   = 4,
    parameter int NOM_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] rate,
    output logic [STEP_W-1:0] step
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    logic              ovf;
    logic              unf;

    // Sign-extended sum; the top two bits disagree exactly on range exit
    always_comb begin
        sum = {acc_q[FRAC_W-1], acc_q} + {rate[FRAC_W-1], rate};
        ovf = (sum[FRAC_W:FRAC_W-1] == 2'b01);
        unf = (sum[FRAC_W:FRAC_W-1] == 2'b10);
        if (ovf)      step = STEP_W'(NOM_STEP + 1);
        else if (unf) step = STEP_W'(NOM_STEP - 1);
        else          step = STEP_W'(NOM_STEP);
    end

    // Wrapped accumulator update (dropping the top bit removes 2^FRAC_W)
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[FRAC_W-1:0];
    end

    // R3: after a carry the wrapped remainder is negative
    a_r3_carry_wraps_negative: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> acc_q[FRAC_W-1]);
    // R3: after a borrow the wrapped remainder is non-negative
    a_r3_borrow_wraps_positive: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> !acc_q[FRAC_W-1]);
endmodule

// File: rtl/tod_raw_counter.sv
// Raw (drift-adjusted) seconds/nanoseconds counter.
// Advances the nanoseconds by the step each cycle and carries the excess
// above one second into the seconds. A load replaces the step with an absolute
// time; an out-of-range nanosecond load value is clamped.
// Assumes: step never exceeds NOM_STEP + 1.
module tod_raw_counter #(
    parameter int SEC_W    = 48,
    parameter int NS_W     = 32,
    parameter int STEP_W   = 4,
    parameter int NOM_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    input  logic              load_en,
    input  logic [NS_W-1:0]   load_ns,
    input  logic [SEC_W-1:0]  load_sec,
    output logic [NS_W-1:0]   cnt_ns,
    output logic [SEC_W-1:0]  cnt_sec
);
    import tod_pkg::NS_PER_SEC;
    import tod_pkg::NS_MAX;

    logic [NS_W-1:0] ns_sum;
    logic            wrap;
    logic [NS_W-1:0] ld_ns_clamped;

    // Next nanoseconds before wrap, wrap detect and load clamp
    always_comb begin
        ns_sum        = cnt_ns + NS_W'(step);
        wrap          = (ns_sum >= NS_PER_SEC);
        ld_ns_clamped = (load_ns >= NS_PER_SEC) ? NS_MAX : load_ns;
    end

    // Counter state: reset, load or step with carry into seconds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_ns  <= '0;
            cnt_sec <= '0;
        end else if (load_en) begin
            cnt_ns  <= ld_ns_clamped;
            cnt_sec <= load_sec;
        end else if (wrap) begin
            cnt_ns  <= ns_sum - NS_PER_SEC;
            cnt_sec <= cnt_sec + SEC_W'(1);
        end else begin
            cnt_ns  <= ns_sum;
        end
    end

    // R4: nanoseconds never leave the one-second range
    a_r4_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ns < NS_PER_SEC);
    // R4: a backward nanosecond move without a load means one second carried
    a_r4_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_en) && (cnt_ns < $past(cnt_ns)))
        |-> (cnt_sec == $past(cnt_sec) + SEC_W'(1)));
    // R2: without a load or wrap each step is within one of nominal
    a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_en) && (cnt_ns >= $past(cnt_ns)))
        |-> ((cnt_sec == $past(cnt_sec)) &&
             ((cnt_ns - $past(cnt_ns)) >= NS_W'(NOM_STEP - 1)) &&
             ((cnt_ns - $past(cnt_ns)) <= NS_W'(NOM_STEP + 1))));
endmodule

// File: rtl/tod_offset_adder.sv
// Combinational offset adder with normalization.
// Adds a signed nanosecond offset (saturated to one second less one ns) and a
// two's-complement seconds offset to the raw time, borrowing or carrying one
// second so the nanosecond result stays within a second.
// Assumes: raw_ns is below one second.
module tod_offset_adder #(
    parameter int SEC_W = 48,
    parameter int NS_W  = 32
) (
    input  logic [NS_W-1:0]  raw_ns,
    input  logic [SEC_W-1:0] raw_sec,
    input  logic [NS_W-1:0]  off_ns,
    input  logic [SEC_W-1:0] off_sec,
    output logic [NS_W-1:0]  out_ns,
    output logic [SEC_W-1:0] out_sec
);
    import tod_pkg::NS_PER_SEC;
    import tod_pkg::NS_MAX;

    localparam logic [NS_W-1:0] NEG_LIM = ~NS_MAX + 1'b1;

    logic [NS_W-1:0]  sat;
    logic [NS_W+1:0]  tsum;
    logic [NS_W+1:0]  fixed;
    logic             neg;
    logic             over;
    logic [SEC_W-1:0] sec_adj;

    // Saturate, add, then fold the sum back into one second
    always_comb begin
        if (!off_ns[NS_W-1] && (off_ns > NS_MAX))     sat = NS_MAX;
        else if (off_ns[NS_W-1] && (off_ns < NEG_LIM)) sat = NEG_LIM;
        else                                           sat = off_ns;
        tsum = {2'b00, raw_ns} + {{2{sat[NS_W-1]}}, sat};
        neg  = tsum[NS_W+1];
        over = !neg && (tsum[NS_W:0] >= {1'b0, NS_PER_SEC});
        if (neg) begin
            fixed   = tsum + {2'b00, NS_PER_SEC};
            sec_adj = '1;
        end else if (over) begin
            fixed   = tsum - {2'b00, NS_PER_SEC};
            sec_adj = SEC_W'(1);
        end else begin
            fixed   = tsum;
            sec_adj = '0;
        end
        out_ns  = fixed[NS_W-1:0];
        out_sec = raw_sec + off_sec + sec_adj;
    end
endmodule

// File: rtl/tod_hb_capture.sv
// Heartbeat synchronizer and time capture.
// Passes the asynchronous heartbeat through SYNC_STAGES flops, detects a
// rising edge with one more flop and captures the presented time on it.
// Assumes: heartbeat high and low phases each last at least two clocks.
module tod_hb_capture #(
    parameter int SEC_W       = 48,
    parameter int NS_W        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             heartbeat,
    input  logic [NS_W-1:0]  time_ns,
    input  logic [SEC_W-1:0] time_sec,
    output logic [NS_W-1:0]  cap_ns,
    output logic [SEC_W-1:0] cap_sec
);
    logic [SYNC_STAGES:0] chain_q;
    logic                 rise;

    // Rising edge: newest synchronized sample high, one older sample low
    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // Synchronizer and edge-detect shift register
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], heartbeat};
    end

    // Capture registers loaded only on a detected rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ns  <= '0;
            cap_sec <= '0;
        end else if (rise) begin
            cap_ns  <= time_ns;
            cap_sec <= time_sec;
        end
    end

    // R7: capture registers hold between detected edges
    a_r7_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rise)) |-> ($stable(cap_ns) && $stable(cap_sec)));
    // R7: a detected edge stores the time presented on that cycle
    a_r7_cap_take: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rise))
        |-> ((cap_ns == $past(time_ns)) && (cap_sec == $past(time_sec))));
endmodule

// File: rtl/tod_sync_clock.sv
// Drift-adjusted time-of-day counter, top level.
// Holds the software registers (drift rate, offset, load value), drives the
// accumulator, raw counter, offset adder and heartbeat capture, and returns
// register contents on a combinational read port.
// Assumes: one register write per cycle, strobed by reg_we.
module tod_sync_clock #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [tod_pkg::ADDR_W-1:0]   reg_addr,
    input  logic [tod_pkg::REG_W-1:0]    reg_wdata,
    output logic [tod_pkg::REG_W-1:0]    reg_rdata,
    input  logic                         heartbeat,
    output logic [tod_pkg::SEC_W-1:0]    sync_sec,
    output logic [tod_pkg::NS_W-1:0]     sync_ns
);
    import tod_pkg::*;

    localparam int HI_W = SEC_W - REG_W;

    logic [FRAC_W-1:0] drift_q;
    logic [NS_W-1:0]   off_ns_q;
    logic [SEC_W-1:0]  off_sec_q;
    logic [NS_W-1:0]   ld_ns_q;
    logic [SEC_W-1:0]  ld_sec_q;
    logic              load_en;
    logic [STEP_W-1:0] step;
    logic [NS_W-1:0]   raw_ns;
    logic [SEC_W-1:0]  raw_sec;
    logic [NS_W-1:0]   cap_ns;
    logic [SEC_W-1:0]  cap_sec;

    assign load_en = reg_we && (reg_addr == RA_LD_GO);

    // Register writes, visible to the datapath from the next edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drift_q   <= '0;
            off_ns_q  <= '0;
            off_sec_q <= '0;
            ld_ns_q   <= '0;
            ld_sec_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_DRIFT:      drift_q                     <= reg_wdata[FRAC_W-1:0];
                RA_OFF_NS:     off_ns_q                    <= reg_wdata;
                RA_OFF_SEC_LO: off_sec_q[REG_W-1:0]        <= reg_wdata;
                RA_OFF_SEC_HI: off_sec_q[SEC_W-1:REG_W]    <= reg_wdata[HI_W-1:0];
                RA_LD_NS:      ld_ns_q                     <= reg_wdata;
                RA_LD_SEC_LO:  ld_sec_q[REG_W-1:0]         <= reg_wdata;
                RA_LD_SEC_HI:  ld_sec_q[SEC_W-1:REG_W]     <= reg_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            RA_DRIFT:      reg_rdata = {{(REG_W-FRAC_W){drift_q[FRAC_W-1]}}, drift_q};
            RA_OFF_NS:     reg_rdata = off_ns_q;
            RA_OFF_SEC_LO: reg_rdata = off_sec_q[REG_W-1:0];
            RA_OFF_SEC_HI: reg_rdata = {{(REG_W-HI_W){1'b0}}, off_sec_q[SEC_W-1:REG_W]};
            RA_LD_NS:      reg_rdata = ld_ns_q;
            RA_LD_SEC_LO:  reg_rdata = ld_sec_q[REG_W-1:0];
            RA_LD_SEC_HI:  reg_rdata = {{(REG_W-HI_W){1'b0}}, ld_sec_q[SEC_W-1:REG_W]};
            RA_CAP_NS:     reg_rdata = cap_ns;
            RA_CAP_SEC_LO: reg_rdata = cap_sec[REG_W-1:0];
            RA_CAP_SEC_HI: reg_rdata = {{(REG_W-HI_W){1'b0}}, cap_sec[SEC_W-1:REG_W]};
            default:       reg_rdata = '0;
        endcase
    end

    tod_drift_accum #(
        .FRAC_W   (FRAC_W),
        .STEP_W   (STEP_W),
        .NOM_STEP (NOM_STEP)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (drift_q),
        .step  (step)
    );

    tod_raw_counter #(
        .SEC_W    (SEC_W),
        .NS_W     (NS_W),
        .STEP_W   (STEP_W),
        .NOM_STEP (NOM_STEP)
    ) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load_en  (load_en),
        .load_ns  (ld_ns_q),
        .load_sec (ld_sec_q),
        .cnt_ns   (raw_ns),
        .cnt_sec  (raw_sec)
    );

    tod_offset_adder #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W)
    ) u_offset (
        .raw_ns  (raw_ns),
        .raw_sec (raw_sec),
        .off_ns  (off_ns_q),
        .off_sec (off_sec_q),
        .out_ns  (sync_ns),
        .out_sec (sync_sec)
    );

    tod_hb_capture #(
        .SEC_W       (SEC_W),
        .NS_W        (NS_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .heartbeat (heartbeat),
        .time_ns   (sync_ns),
        .time_sec  (sync_sec),
        .cap_ns    (cap_ns),
        .cap_sec   (cap_sec)
    );

    // R5: the normalized synchronized nanoseconds stay within one second
    a_r5_sync_ns_norm: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ns < NS_PER_SEC);
endmodule

// File: tb/tod_sync_clock_bench.sv
module tod_sync_clock_bench;
    localparam longint NSEC   = 64'd1000000000;
    localparam longint HALF   = 64'd536870912;   // 2^29
    localparam longint FULL   = 64'd1073741824;  // 2^30
    localparam int     WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        heartbeat = 1'b0;
    logic [47:0] sync_sec;
    logic [31:0] sync_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit m_valid = 1'b0;

    // Reference model state
    longint      m_acc, m_rate, m_ns, m_offns, m_cap_ns;
    logic [31:0] m_drift_rd, m_offns_raw, m_ldns;
    logic [47:0] m_sec, m_offsec, m_ldsec, m_cap_sec;
    bit          hist[$];

    tod_sync_clock u_tod_sync_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .heartbeat (heartbeat),
        .sync_sec  (sync_sec),
        .sync_ns   (sync_ns)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Offset sum of the model's raw time (R5 rules)
    task automatic calc_sync(output logic [47:0] s, output longint n);
        longint o;
        o = m_offns;
        if (o > NSEC - 1) o = NSEC - 1;
        if (o < -(NSEC - 1)) o = -(NSEC - 1);
        n = m_ns + o;
        s = m_sec + m_offsec;
        if (n < 0) begin n += NSEC; s -= 48'd1; end
        else if (n >= NSEC) begin n -= NSEC; s += 48'd1; end
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_drift_rd;
            4'h1: return m_offns_raw;
            4'h2: return m_offsec[31:0];
            4'h3: return {16'h0, m_offsec[47:32]};
            4'h4: return m_ldns;
            4'h5: return m_ldsec[31:0];
            4'h6: return {16'h0, m_ldsec[47:32]};
            4'h8: return m_cap_ns[31:0];
            4'h9: return m_cap_sec[31:0];
            4'hA: return {16'h0, m_cap_sec[47:32]};
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural reference model, advanced on every clock edge
    always @(posedge clk) begin
        logic [47:0] cs;
        longint cn, sum;
        int step;
        bit rise;
        if (!rst_n) begin
            m_acc = 0; m_rate = 0; m_ns = 0; m_offns = 0; m_cap_ns = 0;
            m_drift_rd = 0; m_offns_raw = 0; m_ldns = 0;
            m_sec = 0; m_offsec = 0; m_ldsec = 0; m_cap_sec = 0;
            hist = {1'b0, 1'b0, 1'b0};
            m_valid = 1'b1;
        end else begin
            calc_sync(cs, cn);
            rise = hist[1] && !hist[0];
            sum = m_acc + m_rate;
            step = 8;
            if (sum >= HALF) begin step = 9; sum -= FULL; end
            else if (sum < -HALF) begin step = 7; sum += FULL; end
            m_acc = sum;
            if (reg_we && reg_addr == 4'h7) begin
                m_ns = (longint'(m_ldns) >= NSEC) ? NSEC - 1 : longint'(m_ldns);
                m_sec = m_ldsec;
            end else begin
                m_ns += step;
                if (m_ns >= NSEC) begin m_ns -= NSEC; m_sec += 48'd1; end
            end
            if (rise) begin m_cap_ns = cn; m_cap_sec = cs; end
            hist.push_back(heartbeat);
            void'(hist.pop_front());
            if (reg_we) begin
                case (reg_addr)
                    4'h0: begin
                        m_rate = longint'($signed(reg_wdata[29:0]));
                        m_drift_rd = {{2{reg_wdata[29]}}, reg_wdata[29:0]};
                    end
                    4'h1: begin
                        m_offns_raw = reg_wdata;
                        m_offns = longint'($signed(reg_wdata));
                    end
                    4'h2: m_offsec[31:0] = reg_wdata;
                    4'h3: m_offsec[47:32] = reg_wdata[15:0];
                    4'h4: m_ldns = reg_wdata;
                    4'h5: m_ldsec[31:0] = reg_wdata;
                    4'h6: m_ldsec[47:32] = reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // Every-cycle comparison of the synchronized time (R2 R3 R4 R5 R6)
    always @(negedge clk) begin
        logic [47:0] es;
        longint en;
        if (rst_n && m_valid && !done) begin
            calc_sync(es, en);
            check(sync_ns == en[31:0], "R2 R3 R4 R5 R6 sync_ns", sync_ns, en);
            check(sync_sec == es, "R2 R3 R4 R5 R6 sync_sec", sync_sec, es);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        reg_addr = a;
        #1;
        e = exp_rd(a);
        check(reg_rdata == e, tag, reg_rdata, e);
    endtask

    task automatic load(input logic [31:0] ns, input logic [47:0] sec);
        wr(4'h4, ns);
        wr(4'h5, sec[31:0]);
        wr(4'h6, {16'h0, sec[47:32]});
        wr(4'h7, 32'h0);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(WD_CYC * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            done = 1'b1;
            $finish;
        end
    end

    initial begin
        longint t0;
        logic [31:0] keep;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(sync_ns == 0, "R1 reset sync_ns", sync_ns, 0);
        check(sync_sec == 0, "R1 reset sync_sec", sync_sec, 0);
        for (int a = 0; a < 16; a++) rd(4'(a), "R1 R8 reset readback");

        // R2: nominal step
        run(3);
        t0 = longint'(sync_ns);
        run(1);
        check(longint'(sync_ns) - t0 == 8, "R2 nominal step", longint'(sync_ns) - t0, 8);

        // R3: drift rates, both signs and the range limits
        wr(4'h0, 32'h1000_0000); run(40);
        rd(4'h0, "R3 R8 drift readback");
        wr(4'h0, 32'h3000_0000); run(40);   // -2^28 in 30 bits
        rd(4'h0, "R3 R8 negative drift sign extension");
        wr(4'h0, 32'h1FFF_FFFF); run(30);   // largest positive rate
        wr(4'h0, 32'h2000_0000); run(30);   // most negative rate
        wr(4'h0, 32'h0000_1234); run(20);

        // R4: wrap with 8, 9 and 7 ns steps
        wr(4'h0, 32'h0);
        run(2);
        load(32'd999_999_995, 48'd5);
        #1;
        check(sync_ns == 32'd999_999_995, "R6 load ns", sync_ns, 999999995);
        if (m_acc == 0) begin
            run(1); #1;
            check(sync_ns == 32'd3, "R4 wrap excess ns", sync_ns, 3);
            check(sync_sec == 48'd6, "R4 wrap seconds", sync_sec, 6);
        end
        wr(4'h0, 32'h1FFF_FFFF);
        load(32'd999_999_980, 48'hFFFF_FFFF_FFFF);
        run(10);
        wr(4'h0, 32'h2000_0000);
        load(32'd999_999_980, 48'd77);
        run(10);

        // R5: offset borrow, carry, saturation, negative seconds
        wr(4'h0, 32'h0);
        rd(4'h0, "R8 drift readback zero");
        wr(4'h1, 32'hFFFF_FFF6);             // -10 ns
        load(32'd2, 48'd5);
        rd(4'h1, "R5 R8 offset ns readback");
        wr(4'h1, 32'd999_999_999); run(5);
        wr(4'h1, 32'h7FFF_FFFF); run(5);     // saturates high
        wr(4'h1, 32'h8000_0000); run(5);     // saturates low
        rd(4'h1, "R5 R8 offset ns raw readback");
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h3, 32'h0000_FFFF);             // seconds offset -1
        run(5);
        rd(4'h2, "R5 R8 offset sec low");
        rd(4'h3, "R5 R8 offset sec high");
        wr(4'h1, 32'hC465_3601);             // -999,999,999
        load(32'd0, 48'd0);
        #1;
        check(sync_ns == 32'd1, "R5 borrow ns", sync_ns, 1);
        check(sync_sec == 48'hFFFF_FFFF_FFFE, "R5 borrow seconds", sync_sec, 64'hFFFF_FFFF_FFFE);
        wr(4'h1, 32'h0); wr(4'h2, 32'h0); wr(4'h3, 32'h0);

        // R6: load clamp
        load(32'hFFFF_FFFF, 48'h1234_5678_9ABC);
        #1;
        check(sync_ns == 32'd999_999_999, "R6 load clamp", sync_ns, 999999999);
        rd(4'h4, "R6 R8 load ns readback");
        rd(4'h6, "R6 R8 load sec high readback");
        rd(4'h7, "R8 go address reads zero");
        rd(4'hF, "R8 unmapped reads zero");

        // R7: heartbeat capture, held level, second pulse
        run(3);
        @(negedge clk); heartbeat = 1'b1;
        run(5);
        rd(4'h8, "R7 R8 capture ns");
        rd(4'h9, "R7 R8 capture sec low");
        rd(4'hA, "R7 R8 capture sec high");
        keep = reg_rdata;
        rd(4'h8, "R7 capture ns");
        keep = reg_rdata;
        run(20);
        rd(4'h8, "R7 held heartbeat no recapture");
        check(reg_rdata == keep, "R7 held heartbeat stable", reg_rdata, keep);
        @(negedge clk); heartbeat = 1'b0;
        run(4);
        @(negedge clk); heartbeat = 1'b1;
        @(negedge clk); heartbeat = 1'b0;
        @(negedge clk); heartbeat = 1'b0;
        run(4);
        rd(4'h8, "R7 second pulse capture");
        wr(4'h0, 32'h1555_5555);
        @(negedge clk); heartbeat = 1'b1;
        run(6);
        rd(4'h8, "R7 capture under drift");
        rd(4'h9, "R7 capture sec under drift");
        run(200);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule